// File: doc/BRIEF.md
# Peripheral-Triggered DMA Channel

A single DMA channel that copies data between a 4K-byte register file and the peripheral control registers in the top 256-byte page of the same 12-bit address space. Each transfer is started by a hardware event from a peripheral that a 3-bit source code selects. The CPU does not need to run any code for a transfer. Software programs four registers through a small write port:

- a control word;
- an 8-bit peripheral offset;
- a first register-file address;
- a last register-file address.

After that, every selected event moves one byte or one two-byte word. The channel walks the register-file address upward as it goes. When the byte at the last address has been moved, the channel either stops or wraps back to the first address. At that point it can also raise an interrupt.

The channel drives a single synchronous memory port. A read returns data one cycle after the read strobe. The channel writes that data to the destination address in the following cycle. Ten request lines enter the block:

| Lines | Events |
|---|---|
| 0 to 3 | timers 0 to 3 |
| 4 / 5 | serial port 0 receive-valid / transmit-empty |
| 6 / 7 | serial port 1 receive-valid / transmit-empty |
| 8 / 9 | I2C receive / transmit |

The parameter `CHAN_IDX` chooses which event of each pair this channel answers to.

Control word layout, in `cfg_wdata_i[7:0]`:

| Bits | Meaning |
|---|---|
| [0] | enable |
| [1] | wrap |
| [2] | direction |
| [3] | interrupt enable |
| [4] | word mode |
| [7:5] | source code |

Register select codes for `cfg_sel_i`: 0 = control, 1 = peripheral offset, 2 = first address, 3 = last address.

Top module: `dma_chan`

## Requirements
- R1: After reset, `busy_o`, `chan_en_o`, `irq_o`, `align_err_o`, `mem_re_o` and `mem_we_o` are all 0.
- R2: Source codes 0 to 3 select request lines 0 to 3. Codes 4, 5 and 6 select lines 4+`CHAN_IDX`, 6+`CHAN_IDX` and 8+`CHAN_IDX`. Code 7 never starts a transfer. Events on lines that are not selected move nothing.
- R3: A transfer starts on a rising edge of the selected line. A line held high counts once.
- R4: With direction 0, data is read from the register file and written to peripheral address {4'hF, offset}.
- R5: With direction 1, data is read from the peripheral address and written to the register file.
- R6: In byte mode (bit 4 = 0), each event moves exactly one byte, and the register-file address then advances by 1.
- R7: In word mode, each event moves two bytes. The first byte uses the even peripheral address and register-file address A. The second byte uses the odd peripheral address and A+1. The register-file address then advances by 2.
- R8: Once the byte at the last address has been moved, with wrap = 0 the enable bit clears and later events move nothing.
- R9: With wrap = 1, the register-file address returns to the first address after the last byte, and the channel stays enabled.
- R10: With interrupt enable = 1, `irq_o` pulses high for one cycle when a block completes. With interrupt enable = 0 it stays low.
- R11: One event that arrives during a transfer is held and served right after that transfer. Further events in the same window are dropped.
- R12: In word mode an odd peripheral offset is used with bit 0 cleared, and `align_err_o` is set. `align_err_o` stays set until the next write to the control register.
- R13: The memory port never reads and writes in the same cycle. Every write immediately follows a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 2 | Register select (0 control, 1 offset, 2 first, 3 last) |
| cfg_wdata_i | input | 12 | Register write data |
| req_i | input | 10 | Peripheral event lines |
| mem_re_o | output | 1 | Memory read strobe |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | 12 | Memory address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data, valid one cycle after the read strobe |
| busy_o | output | 1 | Transfer in progress |
| chan_en_o | output | 1 | Current enable bit |
| irq_o | output | 1 | End-of-block interrupt pulse |
| align_err_o | output | 1 | Sticky word-alignment error |

## Verification
The hardest situation to reach is the pending window, which has three cases:

- an event that lands while a word transfer is in flight;
- a second event that lands on the very cycle the first transfer finishes;
- the hand-off to the held event, with no idle cycle in between.

The bench drives the selected line from the falling clock edge with pulses spaced two cycles apart. The first pulse starts a word transfer. The second arrives in its write-low-byte cycle and is held. The third coincides with the final write. The bench then counts memory writes: exactly four writes prove that the held event ran and that the later one was dropped.

// File: rtl/dma_pkg.sv
package dma_pkg;

  // Byte-level transfer sequencer states
  typedef enum logic [2:0] {
    XS_IDLE = 3'd0,
    XS_RD0  = 3'd1,
    XS_WR0  = 3'd2,
    XS_RD1  = 3'd3,
    XS_WR1  = 3'd4
  } xfer_state_e;

  // Control word, bit 0 = enable
  typedef struct packed {
    logic [2:0] src;
    logic       word;
    logic       irq_en;
    logic       dir;
    logic       wrap;
    logic       en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  localparam logic [1:0] CFG_CTRL  = 2'd0;
  localparam logic [1:0] CFG_IO    = 2'd1;
  localparam logic [1:0] CFG_FIRST = 2'd2;
  localparam logic [1:0] CFG_LAST  = 2'd3;

  localparam logic [2:0] SRC_NONE = 3'd7;

endpackage

// File: rtl/dma_rst_sync.sv
module dma_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];

endmodule

// File: rtl/dma_req_sel.sv
module dma_req_sel #(
  parameter int CHAN_IDX = 0,
  parameter int REQ_W    = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REQ_W-1:0] req_i,
  input  logic [2:0]       src_i,
  output logic             trig_o
);
  import dma_pkg::*;

  localparam int IW = $clog2(REQ_W);

  logic [IW-1:0] line_idx;
  logic          line_ok;
  logic          sel_d;
  logic          sel_q;

  // Shared-event codes: pairs of lines, CHAN_IDX picks the member
  always_comb begin
    line_ok = (src_i != SRC_NONE);
    if (src_i[2]) line_idx = IW'(4 + 2 * int'(src_i[1:0]) + CHAN_IDX);
    else          line_idx = IW'(src_i);
    sel_d = line_ok & req_i[line_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= 1'b0;
    else        sel_q <= sel_d;
  end

  assign trig_o = sel_d & ~sel_q;

endmodule

// File: rtl/dma_xfer_fsm.sv
module dma_xfer_fsm #(
  parameter int AW = 12,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          word_i,
  input  logic          dir_i,
  input  logic [AW-1:0] rf_addr_i,
  input  logic [AW-1:0] per_addr_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          mem_re_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          word_o
);
  import dma_pkg::*;

  xfer_state_e state_q, state_d;
  logic        word_q, word_d;
  logic        dir_q, dir_d;
  logic        hi_byte;
  logic        reading;
  logic [AW-1:0] rf_byte;
  logic [AW-1:0] per_byte;

  always_comb begin
    state_d = state_q;
    word_d  = word_q;
    dir_d   = dir_q;
    unique case (state_q)
      XS_IDLE: if (start_i) state_d = XS_RD0;
      XS_RD0:  state_d = XS_WR0;
      XS_WR0: begin
        if (word_q)       state_d = XS_RD1;
        else if (start_i) state_d = XS_RD0;
        else              state_d = XS_IDLE;
      end
      XS_RD1:  state_d = XS_WR1;
      XS_WR1:  state_d = start_i ? XS_RD0 : XS_IDLE;
      default: state_d = XS_IDLE;
    endcase
    if (start_i && state_d == XS_RD0) begin
      word_d = word_i;
      dir_d  = dir_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= XS_IDLE;
      word_q  <= 1'b0;
      dir_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      word_q  <= word_d;
      dir_q   <= dir_d;
    end
  end

  always_comb begin
    hi_byte  = (state_q == XS_RD1) || (state_q == XS_WR1);
    reading  = (state_q == XS_RD0) || (state_q == XS_RD1);
    rf_byte  = rf_addr_i + AW'(hi_byte);
    per_byte = {per_addr_i[AW-1:1], per_addr_i[0] | hi_byte};
    if (reading) mem_addr_o = dir_q ? per_byte : rf_byte;
    else         mem_addr_o = dir_q ? rf_byte  : per_byte;
  end

  assign mem_re_o    = reading;
  assign mem_we_o    = (state_q == XS_WR0) || (state_q == XS_WR1);
  assign mem_wdata_o = mem_rdata_i;
  assign busy_o      = (state_q != XS_IDLE);
  assign done_o      = ((state_q == XS_WR0) && !word_q) || (state_q == XS_WR1);
  assign word_o      = word_q;

endmodule

// File: rtl/dma_chan.sv
module dma_chan #(
  parameter int CHAN_IDX = 0,
  parameter int AW       = 12,
  parameter int DW       = 8,
  parameter int IO_W     = 8,
  parameter int REQ_W    = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we_i,
  input  logic [1:0]       cfg_sel_i,
  input  logic [AW-1:0]    cfg_wdata_i,
  input  logic [REQ_W-1:0] req_i,
  output logic             mem_re_o,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [DW-1:0]    mem_wdata_o,
  input  logic [DW-1:0]    mem_rdata_i,
  output logic             busy_o,
  output logic             chan_en_o,
  output logic             irq_o,
  output logic             align_err_o
);
  import dma_pkg::*;

  localparam int PW = AW - IO_W;

  logic rst_s;

  ctrl_t           ctrl_q, ctrl_d;
  logic            ctrl_ld;
  logic [IO_W-1:0] io_q;
  logic [AW-1:0]   first_q, last_q;
  logic [AW-1:0]   rf_q, rf_d;
  logic            rf_ld;
  logic            pend_q, pend_d;
  logic            err_q, err_d;
  logic            irq_q, irq_d;

  logic wr_ctrl, wr_io, wr_first, wr_last;
  logic trig;
  logic go;
  logic xfer_busy, xfer_done, xfer_word;
  logic terminal, stop_now, en_live;
  logic [AW-1:0] per_base;
  logic [AW-1:0] step;
  logic [2:0]    src_w;

  dma_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_s)
  );

  assign src_w = ctrl_q.src;

  dma_req_sel #(.CHAN_IDX(CHAN_IDX), .REQ_W(REQ_W)) u_sel (
    .clk    (clk),
    .rst_n  (rst_s),
    .req_i  (req_i),
    .src_i  (src_w),
    .trig_o (trig)
  );

  // Peripheral page is the top page; low bit forced even in word mode
  assign per_base = {{PW{1'b1}}, io_q[IO_W-1:1], io_q[0] & ~ctrl_q.word};

  dma_xfer_fsm #(.AW(AW), .DW(DW)) u_xfer (
    .clk         (clk),
    .rst_n       (rst_s),
    .start_i     (go),
    .word_i      (ctrl_q.word),
    .dir_i       (ctrl_q.dir),
    .rf_addr_i   (rf_q),
    .per_addr_i  (per_base),
    .mem_rdata_i (mem_rdata_i),
    .mem_re_o    (mem_re_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .busy_o      (xfer_busy),
    .done_o      (xfer_done),
    .word_o      (xfer_word)
  );

  // Next-state logic
  always_comb begin
    wr_ctrl  = cfg_we_i && (cfg_sel_i == CFG_CTRL);
    wr_io    = cfg_we_i && (cfg_sel_i == CFG_IO);
    wr_first = cfg_we_i && (cfg_sel_i == CFG_FIRST);
    wr_last  = cfg_we_i && (cfg_sel_i == CFG_LAST);

    step     = xfer_word ? AW'(2) : AW'(1);
    terminal = (rf_q == last_q) || (xfer_word && ((rf_q + AW'(1)) == last_q));
    stop_now = xfer_done && terminal && !ctrl_q.wrap;
    en_live  = ctrl_q.en && !stop_now;
    go       = en_live && (!xfer_busy || xfer_done) && (pend_q || trig);

    ctrl_d = ctrl_q;
    if (stop_now) ctrl_d.en = 1'b0;
    if (wr_ctrl)  ctrl_d = ctrl_t'(cfg_wdata_i[CTRL_W-1:0]);
    ctrl_ld = wr_ctrl || stop_now;

    rf_ld = wr_first || xfer_done;
    if (wr_first)      rf_d = cfg_wdata_i;
    else if (terminal) rf_d = first_q;
    else               rf_d = rf_q + step;

    if (go)                                              pend_d = 1'b0;
    else if (xfer_busy && !xfer_done && ctrl_q.en && trig) pend_d = 1'b1;
    else if (en_live)                                    pend_d = pend_q;
    else                                                 pend_d = 1'b0;

    if (go && ctrl_q.word && io_q[0]) err_d = 1'b1;
    else if (wr_ctrl)                 err_d = 1'b0;
    else                              err_d = err_q;

    irq_d = xfer_done && terminal && ctrl_q.irq_en;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      ctrl_q  <= '0;
      io_q    <= '0;
      first_q <= '0;
      last_q  <= '0;
      rf_q    <= '0;
      pend_q  <= 1'b0;
      err_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      if (ctrl_ld)  ctrl_q  <= ctrl_d;
      if (wr_io)    io_q    <= cfg_wdata_i[IO_W-1:0];
      if (wr_first) first_q <= cfg_wdata_i;
      if (wr_last)  last_q  <= cfg_wdata_i;
      if (rf_ld)    rf_q    <= rf_d;
      pend_q <= pend_d;
      err_q  <= err_d;
      irq_q  <= irq_d;
    end
  end

  assign busy_o      = xfer_busy;
  assign chan_en_o   = ctrl_q.en;
  assign irq_o       = irq_q;
  assign align_err_o = err_q;

endmodule

// File: rtl/dma_chan_chk.sv
module dma_chan_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mem_re,
  input logic       mem_we,
  input logic       busy,
  input logic       chan_en,
  input logic       irq,
  input logic       align_err,
  input logic       cfg_we,
  input logic [1:0] cfg_sel,
  input logic [2:0] src,
  input logic       done
);

  assert_rw_exclusive_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_re && mem_we));

  assert_wr_after_rd_R13: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(mem_re));

  // Code 7 never launches a transfer
  assert_reserved_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (src == 3'd7 && !busy) |=> !busy);

  assert_irq_at_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(done));

  assert_irq_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  assert_en_clear_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(chan_en) |-> ($past(done) || $past(cfg_we)));

  assert_err_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (align_err && !(cfg_we && cfg_sel == 2'd0)) |=> align_err);

endmodule

bind dma_chan dma_chan_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_s),
  .mem_re    (mem_re_o),
  .mem_we    (mem_we_o),
  .busy      (busy_o),
  .chan_en   (chan_en_o),
  .irq       (irq_o),
  .align_err (align_err_o),
  .cfg_we    (cfg_we_i),
  .cfg_sel   (cfg_sel_i),
  .src       (src_w),
  .done      (xfer_done)
);

// File: tb/sim_dma_chan.sv
module sim_dma_chan;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_sel;
  logic [11:0] cfg_wdata;
  logic [9:0]  req;
  logic        mem_re, mem_we;
  logic [11:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata;
  logic        busy, chan_en, irq, align_err;

  always #10 clk = ~clk;

  dma_chan u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we_i    (cfg_we),
    .cfg_sel_i   (cfg_sel),
    .cfg_wdata_i (cfg_wdata),
    .req_i       (req),
    .mem_re_o    (mem_re),
    .mem_we_o    (mem_we),
    .mem_addr_o  (mem_addr),
    .mem_wdata_o (mem_wdata),
    .mem_rdata_i (mem_rdata),
    .busy_o      (busy),
    .chan_en_o   (chan_en),
    .irq_o       (irq),
    .align_err_o (align_err)
  );

  // Bench memory: low page at 0..255, peripheral page at 256..511
  logic [7:0] mem [0:511];

  function automatic int ix(input logic [11:0] a);
    return (a[11:8] == 4'hF) ? 256 + int'(a[7:0]) : int'(a[7:0]);
  endfunction

  always @(posedge clk) begin
    if (mem_re) mem_rdata <= mem[ix(mem_addr)];
    if (mem_we) mem[ix(mem_addr)] <= mem_wdata;
  end

  int   n_chk = 0;
  int   n_bad = 0;
  int   wr_cnt = 0;
  int   irq_cnt = 0;
  int   rw_bad = 0;
  logic re_d = 1'b0;

  always @(posedge clk) begin
    if (mem_we) wr_cnt++;
    if (irq) irq_cnt++;
    if (mem_we && !re_d) rw_bad++;
    if (mem_re && mem_we) rw_bad++;
    re_d <= mem_re;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] ctl(input bit en, input bit wrap, input bit dir,
                                      input bit ie, input bit word, input logic [2:0] src);
    return {4'h0, src, word, ie, dir, wrap, en};
  endfunction

  task automatic cfg(input logic [1:0] sel, input logic [11:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic setup(input logic [7:0] io, input logic [11:0] first, input logic [11:0] last,
                       input logic [11:0] c);
    cfg(2'd1, {4'h0, io});
    cfg(2'd2, first);
    cfg(2'd3, last);
    cfg(2'd0, c);
  endtask

  task automatic pulse(input int line);
    @(negedge clk); req[line] = 1'b1;
    @(negedge clk); req[line] = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic t_reset;
    chk(!busy && !chan_en && !irq && !align_err && !mem_re && !mem_we, "R1 reset outputs",
        {busy, chan_en, irq, align_err, mem_re, mem_we}, 0);
  endtask

  task automatic t_byte_out;
    int w0, i0;
    mem[8'h10] = 8'hA0; mem[8'h11] = 8'hA1; mem[8'h12] = 8'hA2;
    setup(8'h40, 12'h010, 12'h012, ctl(1, 0, 0, 0, 0, 3'd1));
    w0 = wr_cnt; i0 = irq_cnt;
    pulse(1);
    chk(mem[256 + 8'h40] == 8'hA0, "R4 first byte to periph", mem[256 + 8'h40], 8'hA0);
    chk(wr_cnt == w0 + 1, "R6 one byte per request", wr_cnt - w0, 1);
    pulse(0);
    chk(wr_cnt == w0 + 1, "R2 unselected timer ignored", wr_cnt - w0, 1);
    pulse(1);
    chk(mem[256 + 8'h40] == 8'hA1, "R6 address step 1", mem[256 + 8'h40], 8'hA1);
    chk(chan_en == 1'b1, "R8 still enabled mid-block", chan_en, 1);
    pulse(1);
    chk(mem[256 + 8'h40] == 8'hA2, "R8 last byte moved", mem[256 + 8'h40], 8'hA2);
    chk(chan_en == 1'b0, "R8 enable cleared at end", chan_en, 0);
    chk(irq_cnt == i0, "R10 no irq when disabled", irq_cnt - i0, 0);
    pulse(1);
    chk(wr_cnt == w0 + 3, "R8 stopped after block", wr_cnt - w0, 3);
  endtask

  task automatic t_word_in;
    int w0, i0;
    mem[256 + 8'h20] = 8'h5A; mem[256 + 8'h21] = 8'hC3;
    setup(8'h20, 12'h030, 12'h033, ctl(1, 0, 1, 1, 1, 3'd3));
    w0 = wr_cnt; i0 = irq_cnt;
    pulse(3);
    chk(mem[8'h30] == 8'h5A && mem[8'h31] == 8'hC3, "R5 R7 word into rf",
        {mem[8'h30], mem[8'h31]}, 16'h5AC3);
    chk(wr_cnt == w0 + 2, "R7 two bytes per request", wr_cnt - w0, 2);
    mem[256 + 8'h20] = 8'h66; mem[256 + 8'h21] = 8'h99;
    pulse(3);
    chk(mem[8'h32] == 8'h66 && mem[8'h33] == 8'h99, "R7 address step 2",
        {mem[8'h32], mem[8'h33]}, 16'h6699);
    chk(irq_cnt == i0 + 1, "R10 irq once at end", irq_cnt - i0, 1);
    chk(chan_en == 1'b0, "R8 word block stops", chan_en, 0);
  endtask

  task automatic t_wrap;
    int i0;
    mem[8'h50] = 8'h11; mem[8'h51] = 8'h22;
    setup(8'h60, 12'h050, 12'h051, ctl(1, 1, 0, 1, 0, 3'd2));
    i0 = irq_cnt;
    pulse(2);
    chk(mem[256 + 8'h60] == 8'h11, "R9 first", mem[256 + 8'h60], 8'h11);
    pulse(2);
    chk(mem[256 + 8'h60] == 8'h22, "R9 last", mem[256 + 8'h60], 8'h22);
    chk(irq_cnt == i0 + 1, "R10 irq on wrap", irq_cnt - i0, 1);
    pulse(2);
    chk(mem[256 + 8'h60] == 8'h11, "R9 reloaded first", mem[256 + 8'h60], 8'h11);
    chk(chan_en == 1'b1, "R9 stays enabled", chan_en, 1);
    cfg(2'd0, 12'h000);
  endtask

  task automatic t_level;
    int w0;
    setup(8'h70, 12'h090, 12'h09F, ctl(1, 0, 0, 0, 0, 3'd2));
    w0 = wr_cnt;
    @(negedge clk); req[2] = 1'b1;
    repeat (12) @(negedge clk);
    req[2] = 1'b0;
    repeat (4) @(negedge clk);
    chk(wr_cnt == w0 + 1, "R3 held level counts once", wr_cnt - w0, 1);
  endtask

  task automatic t_pending;
    int w0;
    mem[256 + 8'h22] = 8'h31; mem[256 + 8'h23] = 8'h32;
    setup(8'h22, 12'h0A0, 12'h0AF, ctl(1, 0, 1, 0, 1, 3'd0));
    w0 = wr_cnt;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); req[0] = 1'b1;
      @(negedge clk); req[0] = 1'b0;
    end
    repeat (12) @(negedge clk);
    chk(wr_cnt == w0 + 4, "R11 one held, one dropped", wr_cnt - w0, 4);
    chk(mem[8'hA2] == 8'h31 && mem[8'hA3] == 8'h32, "R11 held request data",
        {mem[8'hA2], mem[8'hA3]}, 16'h3132);
  endtask

  task automatic t_shared_map;
    int w0;
    setup(8'h44, 12'h0B0, 12'h0BF, ctl(1, 0, 0, 0, 0, 3'd4));
    w0 = wr_cnt;
    pulse(5);
    chk(wr_cnt == w0, "R2 other-channel line ignored", wr_cnt - w0, 0);
    pulse(4);
    chk(wr_cnt == w0 + 1, "R2 code 4 uses line 4", wr_cnt - w0, 1);
    cfg(2'd0, ctl(1, 0, 0, 0, 0, 3'd6));
    pulse(8);
    chk(wr_cnt == w0 + 2, "R2 code 6 uses line 8", wr_cnt - w0, 2);
    cfg(2'd0, ctl(1, 0, 0, 0, 0, 3'd7));
    for (int l = 0; l < 10; l++) pulse(l);
    chk(wr_cnt == w0 + 2, "R2 code 7 never starts", wr_cnt - w0, 2);
  endtask

  task automatic t_misalign;
    mem[256 + 8'h40] = 8'h12; mem[256 + 8'h41] = 8'h34;
    setup(8'h41, 12'h0C0, 12'h0CF, ctl(1, 0, 1, 0, 1, 3'd1));
    chk(align_err == 1'b0, "R12 clear before use", align_err, 0);
    pulse(1);
    chk(mem[8'hC0] == 8'h12 && mem[8'hC1] == 8'h34, "R12 forced even",
        {mem[8'hC0], mem[8'hC1]}, 16'h1234);
    chk(align_err == 1'b1, "R12 error set", align_err, 1);
    repeat (5) @(negedge clk);
    chk(align_err == 1'b1, "R12 error sticky", align_err, 1);
    cfg(2'd0, ctl(0, 0, 1, 0, 1, 3'd1));
    chk(align_err == 1'b0, "R12 cleared by control write", align_err, 0);
  endtask

  task automatic finish_run;
    chk(rw_bad == 0, "R13 read-then-write order", rw_bad, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = 8'h00;
    mem_rdata = 8'h00;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = 2'd0; cfg_wdata = '0; req = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_byte_out;
    t_word_in;
    t_wrap;
    t_level;
    t_pending;
    t_shared_map;
    t_misalign;
    finish_run;
  end

endmodule